// File: doc/BRIEF.md
# Flash Status and Write-Protect Controller

This block owns the status byte of a serial flash device and acts as the gatekeeper for every command that modifies the array or the status byte itself. A command decoder upstream presents one decoded operation per cycle, together with a target byte address and, for a status write, the new status value. The block answers with a one-cycle grant or deny pulse. A grant hands the operation to the array sequencer. The block then tracks that sequencer's busy line so that a host polling the status byte sees the write-in-progress bit.

Three protection layers apply. A write-enable latch must be set before every modifying command, and it is consumed by that command. A three-bit protect code shields an upper slice of the array. A status-protect bit, combined with the write-protect pin being driven low, freezes the status byte. A deep power-down state ignores every command except the wake command, which also requests that the device identifier be returned.

The controller has four states. `ST_IDLE` accepts commands. `ST_LAUNCH` waits for the sequencer to raise busy after a grant. `ST_RUN` waits for busy to drop. `ST_SLEEP` is deep power-down. The transitions are:
- IDLE→LAUNCH on a granted command.
- LAUNCH→RUN on busy high.
- RUN→IDLE on busy low.
- IDLE→SLEEP on the sleep command.
- SLEEP→IDLE on the wake command.

Top module: `flash_guard`

## Requirements
- R1: After reset the status byte reads 0x00, `pwr_down` is 0 and no grant, deny or id pulse is produced.
- R2: The status byte layout is:
  - bit0 is write-in-progress.
  - bit1 is the write-enable latch.
  - bits 4:2 hold the protect code.
  - bit7 is the status-protect bit.
  - bits 6:5 always read 0.

  In `ST_IDLE`, op 1 (enable) sets bit1 and op 2 (disable) clears it. The new value is visible one cycle after the command.
- R3: A modifying command is one of op 4 (status write), op 5 (page program), op 6 (sector erase), op 7 (block erase) or op 8 (chip erase). If one arrives while the latch is 0, it produces a `deny` pulse one cycle later and leaves the status byte unchanged.
- R4: Protect code k from 1 to 6 shields addresses whose upper 7−k address bits are all ones, which is the top 1/2^(7−k) of the array. Code 7 shields everything and code 0 shields nothing. Op 5, 6 or 7 aimed at a shielded address is denied and clears the latch. Otherwise it is granted.
- R5: Op 8 (chip erase) is denied, with the latch cleared, whenever the protect code is nonzero. It is granted when the code is 0 and the latch is set.
- R6: `wp_n` passes through a two-stage synchronizer. Op 4 with the latch set behaves as follows:
  - If the status-protect bit is 1 and the synchronized `wp_n` is 0, it is denied and the latch is cleared.
  - Otherwise it is granted, and bits 4:2 and bit7 of `cmd_wdata` are loaded into the status byte in the same cycle as the grant.
- R7: Write-in-progress reads 1 from the cycle of the grant until the cycle after `seq_busy` is seen low in `ST_RUN`. It stays 1 for as long as `seq_busy` has not yet risen after the grant.
- R8: When a granted cycle completes (RUN→IDLE), the latch clears.
- R9: While write-in-progress is 1, every command is ignored. No pulse is produced and the latch does not change.
- R10: Op 9 enters `ST_SLEEP` and raises `pwr_down` one cycle later. In sleep, every op except op 10 is ignored. Op 10 returns to `ST_IDLE` and pulses `id_req`. In `ST_IDLE`, op 10 also pulses `id_req`.
- R11: At most one of `grant`, `deny` and `id_req` is high in any cycle. On a grant, `grant_op` carries the granted op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Op code (0 none, 1 enable, 2 disable, 3 read status, 4 status write, 5 program, 6 sector erase, 7 block erase, 8 chip erase, 9 sleep, 10 wake) |
| cmd_addr | input | ADDR_W (19) | Target byte address |
| cmd_wdata | input | 8 | New status value for op 4 |
| wp_n | input | 1 | Write-protect pin, active low, asynchronous |
| seq_busy | input | 1 | Array sequencer is running a cycle |
| grant | output | 1 | One-cycle pulse: command allowed |
| grant_op | output | 4 | Op code of the granted command |
| deny | output | 1 | One-cycle pulse: command refused |
| id_req | output | 1 | One-cycle pulse: return device identifier |
| status | output | 8 | Status byte |
| pwr_down | output | 1 | Deep power-down state |

## Verification
The assertions assume that the sequencer raises `seq_busy` only after a grant and lowers it once per cycle. They also assume that `cmd_op` holds a defined code whenever `cmd_valid` is high. The bench models the sequencer in a task that drives busy only after a grant has been observed, so stimulus never violates these assumptions. The bench also assumes that `wp_n` is held steady for at least three cycles before a status write that depends on it. For that reason, every pin change is followed by three idle cycles before the next status write.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_WREN   = 4'd1,
        OP_WRDI   = 4'd2,
        OP_RDSR   = 4'd3,
        OP_WRSR   = 4'd4,
        OP_PROG   = 4'd5,
        OP_SERASE = 4'd6,
        OP_BERASE = 4'd7,
        OP_CERASE = 4'd8,
        OP_SLEEP  = 4'd9,
        OP_WAKE   = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_SLEEP  = 2'd3
    } st_e;

    localparam int PROT_W = 3;
    localparam int SR_W   = 8;

endpackage

// File: rtl/fg_region_check.sv
module fg_region_check #(
    parameter int ADDR_W = 19,
    parameter int PROT_W = 3
) (
    input  logic [PROT_W-1:0] bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              any_prot
);
    localparam int CODES = 1 << PROT_W;
    localparam int TOP   = CODES - 1;

    logic [CODES-1:0] hit_v;

    assign hit_v[0]   = 1'b0;
    assign hit_v[TOP] = 1'b1;

    generate
        for (genvar g = 1; g < TOP; g++) begin : g_slice
            localparam int NB = TOP - g;
            assign hit_v[g] = &addr[ADDR_W-1 -: NB];
        end
    endgenerate

    assign hit      = hit_v[bp];
    assign any_prot = |bp;

    always_comb begin
        a_r4_full_code_hits: assert (bp != TOP[PROT_W-1:0] || hit);
        a_r4_zero_code_clear: assert (bp != '0 || !hit);
    end

endmodule

// File: rtl/fg_status_reg.sv
module fg_status_reg #(
    parameter int PROT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              load_cfg,
    input  logic [PROT_W-1:0] cfg_bp,
    input  logic              cfg_srp,
    output logic              wel,
    output logic [PROT_W-1:0] bp,
    output logic              srp
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
            bp  <= '0;
            srp <= 1'b0;
        end else begin
            if (clr_wel)      wel <= 1'b0;
            else if (set_wel) wel <= 1'b1;
            if (load_cfg) begin
                bp  <= cfg_bp;
                srp <= cfg_srp;
            end
        end
    end

    a_r2_wel_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wel && !clr_wel) |=> wel);
    a_r8_wel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wel |=> !wel);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int WP_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    input  logic              seq_busy,
    output logic              grant,
    output logic [3:0]        grant_op,
    output logic              deny,
    output logic              id_req,
    output logic [7:0]        status,
    output logic              pwr_down
);
    localparam int BP_LSB = 2;

    st_e  state_q, state_d;
    op_e  op;
    logic wel, srp, hit, any_prot;
    logic [PROT_W-1:0] bp;
    logic set_wel, clr_wel, load_cfg;
    logic grant_d, deny_d, id_d;
    logic grant_q, deny_q, id_q;
    logic [3:0] grant_op_q;
    logic [WP_SYNC-1:0] wp_sync_q;
    logic wp_low, is_mod, blocked, wip;

    assign op = op_e'(cmd_op);

    // write-protect pin synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) wp_sync_q <= '1;
        else        wp_sync_q <= {wp_sync_q[WP_SYNC-2:0], wp_n};
    end
    assign wp_low = !wp_sync_q[WP_SYNC-1];

    fg_region_check #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_region (
        .bp       (bp),
        .addr     (cmd_addr),
        .hit      (hit),
        .any_prot (any_prot)
    );

    fg_status_reg #(.PROT_W(PROT_W)) u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wel  (set_wel),
        .clr_wel  (clr_wel),
        .load_cfg (load_cfg),
        .cfg_bp   (cmd_wdata[BP_LSB +: PROT_W]),
        .cfg_srp  (cmd_wdata[7]),
        .wel      (wel),
        .bp       (bp),
        .srp      (srp)
    );

    assign is_mod  = (op == OP_PROG) || (op == OP_SERASE) ||
                     (op == OP_BERASE) || (op == OP_CERASE);
    assign blocked = (op == OP_CERASE) ? any_prot : hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control
    always_comb begin
        state_d  = state_q;
        set_wel  = 1'b0;
        clr_wel  = 1'b0;
        load_cfg = 1'b0;
        grant_d  = 1'b0;
        deny_d   = 1'b0;
        id_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (op == OP_WREN) begin
                        set_wel = 1'b1;
                    end else if (op == OP_WRDI) begin
                        clr_wel = 1'b1;
                    end else if (op == OP_WRSR) begin
                        if (!wel) begin
                            deny_d = 1'b1;
                        end else if (srp && wp_low) begin
                            deny_d  = 1'b1;
                            clr_wel = 1'b1;
                        end else begin
                            grant_d  = 1'b1;
                            load_cfg = 1'b1;
                            state_d  = ST_LAUNCH;
                        end
                    end else if (is_mod) begin
                        if (!wel) begin
                            deny_d = 1'b1;
                        end else if (blocked) begin
                            deny_d  = 1'b1;
                            clr_wel = 1'b1;
                        end else begin
                            grant_d = 1'b1;
                            state_d = ST_LAUNCH;
                        end
                    end else if (op == OP_SLEEP) begin
                        state_d = ST_SLEEP;
                    end else if (op == OP_WAKE) begin
                        id_d = 1'b1;
                    end
                end
            end
            ST_LAUNCH: begin
                if (seq_busy) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!seq_busy) begin
                    state_d = ST_IDLE;
                    clr_wel = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (cmd_valid && op == OP_WAKE) begin
                    state_d = ST_IDLE;
                    id_d    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q    <= 1'b0;
            deny_q     <= 1'b0;
            id_q       <= 1'b0;
            grant_op_q <= '0;
        end else begin
            grant_q    <= grant_d;
            deny_q     <= deny_d;
            id_q       <= id_d;
            grant_op_q <= grant_d ? cmd_op : 4'd0;
        end
    end

    assign wip      = (state_q == ST_LAUNCH) || (state_q == ST_RUN);
    assign grant    = grant_q;
    assign deny     = deny_q;
    assign id_req   = id_q;
    assign grant_op = grant_op_q;
    assign pwr_down = (state_q == ST_SLEEP);
    assign status   = {srp, 2'b00, bp, wel, wip};

    a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(wel));
    a_r7_grant_sets_wip: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> status[0]);
    a_r8_done_drops_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);
    a_r9_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> !(grant || deny));
    a_r10_wake_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> $past(cmd_valid && cmd_op == OP_WAKE));
    a_r10_no_wip_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down && status[0]));
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, deny, id_req}));

endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;

    typedef struct {
        int         due;
        logic       g;
        logic       d;
        logic       i;
        logic [3:0] op;
        string      tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0;
    logic [3:0] cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [7:0] cmd_wdata = 0;
    logic wp_n = 1, seq_busy = 0;
    logic grant, deny, id_req, pwr_down;
    logic [3:0] grant_op;
    logic [7:0] status;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_guard #(.ADDR_W(AW)) u_flash_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
        .seq_busy(seq_busy), .grant(grant), .grant_op(grant_op), .deny(deny),
        .id_req(id_req), .status(status), .pwr_down(pwr_down)
    );

    // monitor: compare pulses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (grant !== it.g || deny !== it.d || id_req !== it.i ||
                    (it.g && grant_op !== it.op)) begin
                    fails++;
                    $display("FAIL %s: got g=%b d=%b id=%b op=%0d expected g=%b d=%b id=%b op=%0d",
                             it.tag, grant, deny, id_req, grant_op, it.g, it.d, it.i, it.op);
                end
            end else if (grant || deny || id_req) begin
                checks++;
                fails++;
                $display("FAIL R11 unexpected pulse: got g=%b d=%b id=%b expected none",
                         grant, deny, id_req);
            end
        end
    end

    task automatic cmd(input logic [3:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic eg, input logic ed, input logic ei, input string tag);
        exp_t it;
        it.due = cyc + 1; it.g = eg; it.d = ed; it.i = ei; it.op = op; it.tag = tag;
        q.push_back(it);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
    endtask

    task automatic check_status(input logic [7:0] exp, input string tag);
        checks++;
        if (status !== exp) begin
            fails++;
            $display("FAIL %s status: got %02h expected %02h", tag, status, exp);
        end
    endtask

    task automatic check_pd(input logic exp, input string tag);
        checks++;
        if (pwr_down !== exp) begin
            fails++;
            $display("FAIL %s pwr_down: got %b expected %b", tag, pwr_down, exp);
        end
    endtask

    task automatic run_seq(input int n);
        seq_busy = 1;
        repeat (n) @(negedge clk);
        seq_busy = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1: got hung run expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_status(8'h00, "R1");
        check_pd(1'b0, "R1");

        cmd(4'd5, 19'h00100, 0, 0, 1, 0, "R3 program without latch");
        check_status(8'h00, "R3");
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        check_status(8'h02, "R2 latch set");
        cmd(4'd2, 0, 0, 0, 0, 0, "R2 disable");
        check_status(8'h00, "R2 latch cleared");

        // status write: protect code 6 (upper half)
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd4, 0, 8'h18, 1, 0, 0, "R6 status write");
        check_status(8'h1B, "R6 R7 loaded with wip");
        repeat (3) @(negedge clk);
        check_status(8'h1B, "R7 wip held before busy");
        seq_busy = 1;
        cmd(4'd1, 0, 0, 0, 0, 0, "R9 enable ignored");
        cmd(4'd5, 19'h00000, 0, 0, 0, 0, "R9 program ignored");
        check_status(8'h1B, "R9 unchanged while busy");
        seq_busy = 0;
        @(negedge clk);
        check_status(8'h18, "R8 latch cleared at completion");

        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd5, 19'h7FF00, 0, 0, 1, 0, "R4 program in upper half");
        check_status(8'h18, "R4 latch dropped on deny");
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd5, 19'h10000, 0, 1, 0, 0, "R4 program in lower half");
        check_status(8'h1B, "R7 wip");
        run_seq(2);
        check_status(8'h18, "R8");

        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd8, 0, 0, 0, 1, 0, "R5 chip erase with protection");
        check_status(8'h18, "R5");

        // protect code 1: top 1/64
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd4, 0, 8'h04, 1, 0, 0, "R6 status write code1");
        run_seq(1);
        check_status(8'h04, "R6 code1");
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd6, 19'h7E000, 0, 0, 1, 0, "R4 sector erase top 1/64");
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd6, 19'h7DFFF, 0, 1, 0, 0, "R4 sector erase below slice");
        run_seq(1);

        // protect code 7: everything
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd4, 0, 8'h1C, 1, 0, 0, "R6 status write code7");
        run_seq(1);
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd7, 19'h00000, 0, 0, 1, 0, "R4 block erase fully shielded");
        check_status(8'h1C, "R4 code7");

        // status protect with pin
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd4, 0, 8'h80, 1, 0, 0, "R6 set status protect");
        run_seq(1);
        check_status(8'h80, "R6 srp set");
        wp_n = 0;
        repeat (3) @(negedge clk);
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd4, 0, 8'h00, 0, 1, 0, "R6 locked by pin");
        check_status(8'h80, "R6 locked keeps value");
        wp_n = 1;
        repeat (3) @(negedge clk);
        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd4, 0, 8'h00, 1, 0, 0, "R6 pin high unlocks");
        run_seq(1);
        check_status(8'h00, "R6 cleared");

        cmd(4'd1, 0, 0, 0, 0, 0, "R2 enable");
        cmd(4'd8, 0, 0, 1, 0, 0, "R5 chip erase unprotected");
        run_seq(3);
        check_status(8'h00, "R8 after chip erase");

        // deep power-down
        cmd(4'd9, 0, 0, 0, 0, 0, "R10 sleep");
        check_pd(1'b1, "R10 entered");
        cmd(4'd1, 0, 0, 0, 0, 0, "R10 enable ignored");
        check_status(8'h00, "R10 latch untouched");
        cmd(4'd2, 0, 0, 0, 0, 0, "R10 disable ignored");
        check_pd(1'b1, "R10 still asleep");
        cmd(4'd10, 0, 0, 0, 0, 1, "R10 wake with id");
        check_pd(1'b0, "R10 woke");
        cmd(4'd10, 0, 0, 0, 0, 1, "R10 wake in idle gives id");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule